// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is one timer channel of a pulse-width modulator. Software programs a period value and a threshold value into two shadow buffers through a small register write port. It also writes a control word, from which the channel takes its own four-bit slice. The channel keeps an active counter and an active threshold. On every cycle where the tick-enable input is high and the channel is running, the counter steps down by one. The PWM pin is derived from a level that turns on when a decrement lands exactly on the active threshold. That level turns off again when the active registers are reloaded.

There are two ways to move the shadow buffers into the active registers. A manual-update bit copies them every cycle while it is held, and counting is frozen during that time. Alternatively, with auto-reload enabled, the copy happens when a tick finds the counter already at zero, so every period lasts one tick longer than the programmed value. Without auto-reload the channel stops at the end of its period and holds its state. A one-cycle end-of-period pulse marks every expiry.

The position of the channel's control slice inside the shared control word is set by a channel-index parameter. The slice positions leave a gap after the first channel. The final channel of the group has a slice with no polarity bit, so its auto-reload bit moves down one place.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: After reset both buffers, both active registers and all control bits are zero, `period_end` is 0 and `pwm_out` is 1 (the idle level for a cleared polarity bit).
- R2: While the manual-update bit is 1, the active counter and threshold are loaded from the buffers on every clock, no counting takes place and `period_end` stays 0. Counting starts once the bit is written back to 0.
- R3: With start=1, manual-update=0 and auto-reload=1, a loaded period value N gives an expiry every N+1 enabled ticks, since the tick that finds the counter at 0 reloads it.
- R4: The internal level rises only on a tick whose decrement makes the counter equal to the active threshold T, and it falls on every reload. For T<N the level is high for T+1 ticks out of each N+1.
- R5: If the threshold equals the period value, no decrement ever matches, so the level stays low for the whole period.
- R6: A threshold with all bits set (16'hFFFF at the default width) raises the level at load time, so the output is active for the whole period (full duty).
- R7: With auto-reload=0, the channel gives exactly one expiry pulse and then halts with its counter frozen until the next manual update.
- R8: Writes to the buffers during a period do not change that period. The new values take effect only at the next reload.
- R9: With the polarity bit set, `pwm_out` equals the internal level. With it clear, `pwm_out` is the complement of the level.
- R10: With start=0, `pwm_out` sits at the idle level (0 when the polarity bit is set, 1 when it is clear), ticks do nothing and no pulse is issued.
- R11: Control writes use `wr_sel`=2. For channel index c, the slice begins at bit 0 when c=0 and at bit 4*(c+1) otherwise. Within the slice, bit0 is start, bit1 is manual-update, bit2 is polarity and bit3 is auto-reload. For the last channel, bit2 is auto-reload and polarity is fixed at set. At the default index 1 the slice is bits 11:8, and bits outside it have no effect. `wr_sel`=0 writes the period buffer and `wr_sel`=1 writes the threshold buffer, both from `wr_data[15:0]`.
- R12: `period_end` is high for exactly one clock, in the cycle after the clock edge that sampled the expiring tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 period buffer, 1 threshold buffer, 2 control word |
| wr_data | input | 32 | Write data |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| pwm_out | output | 1 | PWM pin |
| period_end | output | 1 | One-clock pulse at each counter expiry |

## Verification
The bench checks the period length of N+1 ticks, because a design without the hidden tick would pulse every N ticks and shorten every period. It sets the threshold equal to the period, which must leave the pin inactive: a design that tested the match before decrementing would instead emit a one-tick glitch. The all-ones threshold must hold full duty, and buffer writes made mid-period must not shorten the running period. A one-shot run must stop after a single pulse, whereas a design that ignored auto-reload would keep running. Random writes and tick gaps mixed with manual updates catch any loading done at the wrong edge.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  // Write target encoding on the register port
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_THRESH = 2'd1,
    SEL_CTRL   = 2'd2
  } reg_sel_e;

  // Per-channel control slice, start in bit 0
  typedef struct packed {
    logic reload;
    logic polarity;
    logic manual;
    logic start;
  } chan_ctrl_t;

  // Slice position inside the shared control word (gap after channel 0)
  function automatic int slice_base(input int idx);
    return (idx == 0) ? 0 : 4 * (idx + 1);
  endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 32,
  parameter int CHAN_IDX = 1,
  parameter int NUM_CHAN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  period_buf,
  output logic [CNT_W-1:0]  thresh_buf,
  output chan_ctrl_t        ctrl
);

  localparam int  SB      = slice_base(CHAN_IDX);
  localparam bit  IS_LAST = (CHAN_IDX == NUM_CHAN - 1);

  chan_ctrl_t ctrl_d;
  logic       unused_bits;

  assign unused_bits = ^wr_data;

  generate
    if (IS_LAST) begin : g_last_slice
      // last channel: reload one bit lower, polarity fixed to normal
      assign ctrl_d = '{reload:   wr_data[SB+2],
                        polarity: 1'b1,
                        manual:   wr_data[SB+1],
                        start:    wr_data[SB]};
    end else begin : g_std_slice
      assign ctrl_d = '{reload:   wr_data[SB+3],
                        polarity: wr_data[SB+2],
                        manual:   wr_data[SB+1],
                        start:    wr_data[SB]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_buf <= '0;
      thresh_buf <= '0;
      ctrl       <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_PERIOD: period_buf <= wr_data[CNT_W-1:0];
        SEL_THRESH: thresh_buf <= wr_data[CNT_W-1:0];
        SEL_CTRL:   ctrl       <= ctrl_d;
        default:    ;
      endcase
    end
  end

  // R11: control slice changes only through a control write
  p_ctrl_write_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_CTRL) |=> $stable(ctrl));

  // R8: period buffer changes only through its own write
  p_buf_write_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_PERIOD) |=> $stable(period_buf));

endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  chan_ctrl_t       ctrl,
  input  logic [CNT_W-1:0] period_buf,
  input  logic [CNT_W-1:0] thresh_buf,
  output logic             load_now,
  output logic             load_full,
  output logic             hit_now,
  output logic             period_end
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] cnt_dec;
  logic             halt_q;
  logic             running;
  logic             step;
  logic             expire;

  assign running   = ctrl.start && !ctrl.manual && !halt_q;
  assign step      = running && tick_en;
  assign expire    = step && (cnt_q == '0);
  assign cnt_dec   = cnt_q - CNT_W'(1);
  assign load_now  = ctrl.manual || (expire && ctrl.reload);
  assign load_full = &thresh_buf;
  // match is only tested on the value produced by a decrement
  assign hit_now   = step && !expire && (cnt_dec == thr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      thr_q <= '0;
    end else if (load_now) begin
      cnt_q <= period_buf;
      thr_q <= thresh_buf;
    end else if (step && !expire) begin
      cnt_q <= cnt_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else if (ctrl.manual) begin
      halt_q <= 1'b0;
    end else if (expire && !ctrl.reload) begin
      halt_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_end <= 1'b0;
    else        period_end <= expire;
  end

  // R3: a counting tick on a nonzero counter lowers it by exactly one
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0 && !ctrl.manual) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R2: manual update leaves the buffers in the active registers
  p_manual_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.manual |=> (cnt_q == $past(period_buf) && thr_q == $past(thresh_buf)));

  // R7: a halted channel keeps its counter and issues no pulse
  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !ctrl.manual) |=> ($stable(cnt_q) && !period_end));

  // R12: the pulse only follows a cycle in which the counter was zero
  p_end_at_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> ($past(cnt_q) == '0));

endmodule

// File: rtl/pwm_chan_outstage.sv
module pwm_chan_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic load_now,
  input  logic load_full,
  input  logic hit_now,
  input  logic start,
  input  logic polarity,
  output logic pwm_out
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level_q <= 1'b0;
    else if (load_now) level_q <= load_full;
    else if (hit_now)  level_q <= 1'b1;
  end

  always_comb begin
    if (!start)        pwm_out = !polarity;
    else if (polarity) pwm_out = level_q;
    else               pwm_out = !level_q;
  end

  // R4: the level rises only after a match or a full-duty load
  p_level_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_q) |-> $past(hit_now || (load_now && load_full)));

  // R4: the level falls only on a reload
  p_level_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(level_q) |-> $past(load_now));

  // R6: an all-ones threshold load leaves the level active
  p_full_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && load_full) |=> level_q);

endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 32,
  parameter int CHAN_IDX = 1,
  parameter int NUM_CHAN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick_en,
  output logic              pwm_out,
  output logic              period_end
);

  logic [CNT_W-1:0] period_buf;
  logic [CNT_W-1:0] thresh_buf;
  chan_ctrl_t       ctrl;
  logic             load_now;
  logic             load_full;
  logic             hit_now;

  pwm_chan_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .CHAN_IDX(CHAN_IDX), .NUM_CHAN(NUM_CHAN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .period_buf(period_buf), .thresh_buf(thresh_buf), .ctrl(ctrl)
  );

  pwm_chan_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl(ctrl),
    .period_buf(period_buf), .thresh_buf(thresh_buf),
    .load_now(load_now), .load_full(load_full), .hit_now(hit_now),
    .period_end(period_end)
  );

  pwm_chan_outstage u_out (
    .clk(clk), .rst_n(rst_n), .load_now(load_now), .load_full(load_full),
    .hit_now(hit_now), .start(ctrl.start), .polarity(ctrl.polarity),
    .pwm_out(pwm_out)
  );

endmodule

// File: tb/pwm_dbuf_channel_tb.sv
module pwm_dbuf_channel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int DATA_W     = 32;
  localparam logic [CNT_W-1:0] ALL1 = '1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [1:0]        wr_sel;
  logic [DATA_W-1:0] wr_data;
  logic              tick_en;
  logic              pwm_out;
  logic              period_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dbuf_channel dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick_en(tick_en), .pwm_out(pwm_out), .period_end(period_end)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int g_pulses;
  int g_high;

  // reference state built from the requirements
  logic [CNT_W-1:0] m_pbuf, m_tbuf, m_cnt, m_thr;
  bit m_start, m_man, m_pol, m_rel, m_level, m_halt, m_pend;

  // R11: channel 1 slice at bits 11:8
  function automatic logic [DATA_W-1:0] mk_ctrl(bit st, bit mu, bit pl, bit rl);
    logic [DATA_W-1:0] d = '0;
    d[8] = st; d[9] = mu; d[10] = pl; d[11] = rl;
    return d;
  endfunction

  function automatic bit exp_pin();
    if (!m_start) return !m_pol;
    return m_pol ? m_level : !m_level;
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(bit we, logic [1:0] sel, logic [DATA_W-1:0] d, bit tick);
    bit stp, exp_now, ld;
    stp     = m_start && !m_man && !m_halt && tick;
    exp_now = stp && (m_cnt == '0);
    ld      = m_man || (exp_now && m_rel);
    m_pend  = exp_now;
    if (ld) begin
      m_cnt = m_pbuf; m_thr = m_tbuf; m_level = (m_tbuf == ALL1);
    end else if (stp && !exp_now) begin
      m_cnt = m_cnt - 1'b1;
      if (m_cnt == m_thr) m_level = 1;
    end
    if (m_man) m_halt = 0;
    else if (exp_now && !m_rel) m_halt = 1;
    if (we) begin
      case (sel)
        2'd0: m_pbuf = d[CNT_W-1:0];
        2'd1: m_tbuf = d[CNT_W-1:0];
        2'd2: begin m_start = d[8]; m_man = d[9]; m_pol = d[10]; m_rel = d[11]; end
        default: ;
      endcase
    end
  endtask

  task automatic step(bit we, logic [1:0] sel, logic [DATA_W-1:0] d, bit tick, string req);
    wr_en = we; wr_sel = sel; wr_data = d; tick_en = tick;
    @(posedge clk);
    model_edge(we, sel, d, tick);
    @(negedge clk);
    wr_en = 0; tick_en = 0;
    check(req, pwm_out, exp_pin());
    check(req, period_end, m_pend);
    if (period_end) g_pulses++;
    if (pwm_out) g_high++;
  endtask

  task automatic wr(logic [1:0] sel, logic [DATA_W-1:0] d, string req);
    step(1, sel, d, 0, req);
  endtask

  task automatic ticks(int n, string req);
    for (int i = 0; i < n; i++) step(0, 2'd0, '0, 1, req);
  endtask

  task automatic clr();
    g_pulses = 0; g_high = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = '0; tick_en = 0;
    m_pbuf = '0; m_tbuf = '0; m_cnt = '0; m_thr = '0;
    m_start = 0; m_man = 0; m_pol = 0; m_rel = 0; m_level = 0; m_halt = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", pwm_out, 1'b1);
    check("R1", period_end, 1'b0);

    // R2: manual update freezes counting
    wr(2'd0, 32'd4, "R2");
    wr(2'd1, 32'd1, "R2");
    wr(2'd2, mk_ctrl(1, 1, 1, 1), "R2");
    clr(); ticks(3, "R2");
    check_int("R2", g_pulses, 0);
    wr(2'd2, mk_ctrl(1, 0, 1, 1), "R2");

    // R3 / R4: period 5 ticks, threshold 1 gives 2 active ticks
    clr(); ticks(10, "R3");
    check_int("R3", g_pulses, 2);
    check_int("R4", g_high, 4);

    // R8: mid-period buffer writes wait for the boundary
    wr(2'd0, 32'd2, "R8");
    wr(2'd1, 32'd0, "R8");
    clr(); ticks(5, "R8");
    check_int("R8", g_pulses, 1);
    check_int("R8", g_high, 2);
    clr(); ticks(3, "R8");
    check_int("R8", g_pulses, 1);
    check_int("R8", g_high, 1);

    // R5: threshold equal to period never matches
    wr(2'd0, 32'd3, "R5");
    wr(2'd1, 32'd3, "R5");
    wr(2'd2, mk_ctrl(1, 1, 1, 1), "R5");
    wr(2'd2, mk_ctrl(1, 0, 1, 1), "R5");
    clr(); ticks(8, "R5");
    check_int("R5", g_high, 0);
    check_int("R5", g_pulses, 2);

    // R6: all-ones threshold gives full duty
    wr(2'd1, 32'(ALL1), "R6");
    wr(2'd2, mk_ctrl(1, 1, 1, 1), "R6");
    wr(2'd2, mk_ctrl(1, 0, 1, 1), "R6");
    clr(); ticks(8, "R6");
    check_int("R6", g_high, 8);

    // R9: polarity cleared complements the level
    wr(2'd2, mk_ctrl(1, 0, 0, 1), "R9");
    clr(); ticks(4, "R9");
    check_int("R9", g_high, 0);

    // R10: start cleared holds idle level and stops counting
    wr(2'd2, mk_ctrl(0, 0, 1, 1), "R10");
    clr(); ticks(6, "R10");
    check_int("R10", g_pulses, 0);
    check_int("R10", g_high, 0);
    wr(2'd2, mk_ctrl(0, 0, 0, 1), "R10");
    check("R10", pwm_out, 1'b1);

    // R11: bits outside the channel slice have no effect
    wr(2'd2, mk_ctrl(0, 0, 0, 1) | 32'hFFFF_F0FF, "R11");
    clr(); ticks(4, "R11");
    check_int("R11", g_pulses, 0);
    check("R11", pwm_out, 1'b1);

    // R7: one-shot halts after a single expiry
    wr(2'd0, 32'd2, "R7");
    wr(2'd1, 32'd0, "R7");
    wr(2'd2, mk_ctrl(1, 1, 1, 0), "R7");
    wr(2'd2, mk_ctrl(1, 0, 1, 0), "R7");
    clr(); ticks(12, "R7");
    check_int("R7", g_pulses, 1);

    // R12: pulse lasts one clock
    wr(2'd0, 32'd1, "R12");
    wr(2'd2, mk_ctrl(1, 1, 1, 1), "R12");
    wr(2'd2, mk_ctrl(1, 0, 1, 1), "R12");
    ticks(2, "R12");
    check("R12", period_end, 1'b1);
    step(0, 2'd0, '0, 0, "R12");
    check("R12", period_end, 1'b0);

    // random mix, checked cycle by cycle against the reference
    for (int i = 0; i < 800; i++) begin
      int r;
      bit tk;
      r  = $urandom_range(0, 99);
      tk = ($urandom_range(0, 9) < 7);
      if (r < 8)
        step(1, 2'd0, 32'($urandom_range(0, 9)), tk, "R4");
      else if (r < 16)
        step(1, 2'd1, ($urandom_range(0, 3) == 0) ? 32'(ALL1) : 32'($urandom_range(0, 10)), tk, "R4");
      else if (r < 24)
        step(1, 2'd2, mk_ctrl($urandom_range(0, 9) < 8, $urandom_range(0, 9) < 3,
                               $urandom_range(0, 1) == 1, $urandom_range(0, 9) < 8), tk, "R4");
      else
        step(0, 2'd0, '0, tk, "R4");
    end

    finish_run();
  end

endmodule